// File: doc/BRIEF.md
# Root Port Legacy Interrupt Queue

This block sits beside a PCIe root port and collects legacy wire-interrupt messages (assert and deassert, each tagged with one of four lanes) that arrive from devices below the port. Each accepted message becomes an entry in a small circular queue. A single level-sensitive interrupt line to the host processor is driven from a pending register gated by a mask register.

Software reaches the block through a 32-bit register port addressed by byte offset. Reads are combinational and have no side effects. A write takes effect at the next rising clock edge. The handler's normal flow is as follows:
- Read the pending register.
- Read the head record of the queue.
- Write either queue read register to discard the head record.
- Once the queue is empty, clear the pending bit through the pending register.

The same port also gives access to:
- a link-up status bit;
- a bridge-enable control bit that leaves the block as an output;
- a sticky flag that records messages lost because the queue was full.

Top module: `intx_queue_ctrl`

## Requirements
- R1: After a synchronous reset the following hold: pending, mask, overflow and bridge-enable read as zero; the queue is empty; `irq` is 0; `bridge_en` is 0.
- R2: The mask register at offset 0x13C stores and returns all 32 written bits.
- R3: `irq` is 1 exactly when the AND of the pending register (0x138) and the mask register is nonzero. It follows the register state that results from each clock edge.
- R4: An accepted event stores a record. The first word, read at 0x158, has bit 31 = 1, bit 29 = assert level, and bits 28:27 = lane. The second word, read at 0x15C, is always zero. Records leave the queue in arrival order. With the queue empty, 0x158 reads zero.
- R5: Accepting an event sets pending bit 16. While the queue holds any record, pending bit 16 is held at 1, so a write that tries to clear it has no effect.
- R6: A write to 0x138 clears each pending bit whose written bit is 1 and leaves all other pending bits unchanged.
- R7: The queue holds DEPTH-1 records. An event that arrives while the queue is full is dropped and sets overflow bit 19 of the status register at 0x148. That bit stays set until software writes 1 to bit 19. If a drop and a clear happen in the same cycle, the set wins.
- R8: A write of any value to 0x158 or 0x15C discards the head record. When the queue is empty such a write changes nothing.
- R9: Bit 0 of 0x148 is a read/write bridge-enable bit that drives `bridge_en`. Bit 18 of 0x148 reads 1 while the queue is non-empty.
- R10: Offset 0x144 returns `link_up` on bit 11 and zero elsewhere. Every offset not listed in these requirements reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | One legacy interrupt message this cycle |
| ev_lane | input | 2 | Lane of the message (0 to 3) |
| ev_level | input | 1 | 1 = assert, 0 = deassert |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| link_up | input | 1 | Link status, reported at 0x144 |
| bridge_en | output | 1 | Bridge-enable control bit |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with DEPTH = 4, so the queue holds only three records. This makes the fill, drop, overflow-flag and wrap-around cases reachable within a handful of events. It also makes the pointers wrap many times during the random phase. ADDR_W stays at 12, which lets the random phase probe unmapped offsets around the mapped window. The random phase mixes the following:
- events;
- mask writes;
- pending clears;
- status writes;
- pops on either read register.

After each operation, every register and both outputs are compared against a model kept in the bench.

// File: rtl/intq_pkg.sv
package intq_pkg;

  localparam int LANE_W = 2;

  // Register byte offsets (software decodes these)
  localparam logic [11:0] OFS_PEND   = 12'h138;
  localparam logic [11:0] OFS_MASK   = 12'h13C;
  localparam logic [11:0] OFS_PHY    = 12'h144;
  localparam logic [11:0] OFS_STAT   = 12'h148;
  localparam logic [11:0] OFS_HEAD_A = 12'h158;
  localparam logic [11:0] OFS_HEAD_B = 12'h15C;

  // Bit positions
  localparam int BIT_INTX   = 16;
  localparam int BIT_LINK   = 11;
  localparam int BIT_BREN   = 0;
  localparam int BIT_NEMPTY = 18;
  localparam int BIT_OVF    = 19;
  localparam int BIT_LANE   = 27;
  localparam int BIT_LEVEL  = 29;
  localparam int BIT_VALID  = 31;

  typedef struct packed {
    logic              level;
    logic [LANE_W-1:0] lane;
  } intq_entry_t;

  function automatic logic [31:0] record_word(input intq_entry_t e);
    logic [31:0] w;
    w = '0;
    w[BIT_VALID] = 1'b1;
    w[BIT_LEVEL] = e.level;
    w[BIT_LANE +: LANE_W] = e.lane;
    return w;
  endfunction

  function automatic logic [31:0] status_word(input logic ovf, input logic nempty,
                                              input logic bren);
    logic [31:0] w;
    w = '0;
    w[BIT_OVF]    = ovf;
    w[BIT_NEMPTY] = nempty;
    w[BIT_BREN]   = bren;
    return w;
  endfunction

  function automatic logic [31:0] pending_next(input logic [31:0] cur, input logic [31:0] clr,
                                               input logic hold_intx);
    logic [31:0] w;
    w = cur & ~clr;
    if (hold_intx) w[BIT_INTX] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/intq_fifo.sv
module intq_fifo
  import intq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  intq_entry_t push_data,
  input  logic        pop,
  output intq_entry_t head,
  output logic        empty,
  output logic        full,
  output logic        push_ok,
  output logic        pop_ok
);

  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  intq_entry_t      slot_q [DEPTH];

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (step(wr_ptr) == rd_ptr);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = slot_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[wr_ptr] <= push_data;
  end

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    push && full |=> $stable(wr_ptr)) else $error("write pointer moved on full push"); // R7
  AST_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop && empty |=> $stable(rd_ptr)) else $error("read pointer moved on empty pop"); // R8

endmodule

// File: rtl/intq_pending.sv
module intq_pending
  import intq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr_we,
  input  logic [31:0] clr_bits,
  input  logic        mask_we,
  input  logic [31:0] mask_wdata,
  input  logic        hold_intx,
  output logic [31:0] pending_q,
  output logic [31:0] mask_q,
  output logic        irq
);

  logic [31:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;
  assign irq     = |(pending_q & mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      mask_q    <= '0;
    end else begin
      pending_q <= pending_next(pending_q, clr_eff, hold_intx);
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_we && !hold_intx |=> (pending_q & $past(clr_bits)) == '0)
    else $error("pending bit survived clear"); // R6

endmodule

// File: rtl/intx_queue_ctrl.sv
module intx_queue_ctrl
  import intq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [LANE_W-1:0] ev_lane,
  input  logic              ev_level,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              link_up,
  output logic              bridge_en,
  output logic              irq
);

  // Named internal events
  logic        hit_pend, hit_mask, hit_stat, hit_pop;
  logic        pend_we, mask_we, stat_we, pop_req;
  logic        fifo_empty, fifo_full, enq_ok, deq_ok, drop_evt;
  intq_entry_t fifo_head, ev_entry;
  logic [31:0] pending_q, mask_q;
  logic        ovf_q, bren_q;

  assign hit_pend = (reg_addr == ADDR_W'(OFS_PEND));
  assign hit_mask = (reg_addr == ADDR_W'(OFS_MASK));
  assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign hit_pop  = (reg_addr == ADDR_W'(OFS_HEAD_A)) || (reg_addr == ADDR_W'(OFS_HEAD_B));

  assign pend_we  = reg_wr && hit_pend;
  assign mask_we  = reg_wr && hit_mask;
  assign stat_we  = reg_wr && hit_stat;
  assign pop_req  = reg_wr && hit_pop;
  assign drop_evt = ev_valid && fifo_full;

  assign ev_entry.level = ev_level;
  assign ev_entry.lane  = ev_lane;

  intq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (ev_valid),
    .push_data(ev_entry),
    .pop      (pop_req),
    .head     (fifo_head),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .push_ok  (enq_ok),
    .pop_ok   (deq_ok)
  );

  intq_pending u_pend (
    .clk       (clk),
    .rst       (rst),
    .clr_we    (pend_we),
    .clr_bits  (reg_wdata),
    .mask_we   (mask_we),
    .mask_wdata(reg_wdata),
    .hold_intx (enq_ok || !fifo_empty),
    .pending_q (pending_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q  <= 1'b0;
      bren_q <= 1'b0;
    end else begin
      if (stat_we) bren_q <= reg_wdata[BIT_BREN];
      if (drop_evt)                         ovf_q <= 1'b1;
      else if (stat_we && reg_wdata[BIT_OVF]) ovf_q <= 1'b0;
    end
  end

  assign bridge_en = bren_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_PEND):   reg_rdata = pending_q;
      ADDR_W'(OFS_MASK):   reg_rdata = mask_q;
      ADDR_W'(OFS_PHY):    reg_rdata[BIT_LINK] = link_up;
      ADDR_W'(OFS_STAT):   reg_rdata = status_word(ovf_q, !fifo_empty, bren_q);
      ADDR_W'(OFS_HEAD_A): reg_rdata = fifo_empty ? '0 : record_word(fifo_head);
      default:             reg_rdata = '0;
    endcase
  end

  AST_INTX_HELD: assert property (@(posedge clk) disable iff (rst)
    !fifo_empty |=> pending_q[BIT_INTX]) else $error("INTx pending dropped"); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !(stat_we && reg_wdata[BIT_OVF]) |=> ovf_q) else $error("overflow lost"); // R7
  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> ovf_q) else $error("drop without overflow"); // R7
  AST_IRQ_ON_ENQ: assert property (@(posedge clk) disable iff (rst)
    enq_ok && mask_q[BIT_INTX] && !mask_we |=> irq) else $error("irq missing"); // R3
  AST_BRIDGE_WRITE: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> bridge_en == $past(reg_wdata[BIT_BREN])) else $error("bridge bit"); // R9

endmodule

// File: tb/test_intx_queue_ctrl.sv
`timescale 1ns/100ps
module test_intx_queue_ctrl;

  localparam int DEPTH = 4;
  localparam int CAP   = DEPTH - 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        ev_valid;
  logic [1:0]  ev_lane;
  logic        ev_level;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        link_up;
  logic        bridge_en;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [31:0] m_pend, m_mask;
  logic        m_ovf, m_br;
  logic [1:0]  m_lane [CAP];
  logic        m_lvl  [CAP];
  int          m_cnt;

  always #4 clk = ~clk;

  intx_queue_ctrl #(.DEPTH(DEPTH), .ADDR_W(12)) i_intx_queue_ctrl (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_lane(ev_lane), .ev_level(ev_level),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_up(link_up), .bridge_en(bridge_en), .irq(irq)
  );

  function automatic logic [31:0] exp_head();
    if (m_cnt == 0) return 32'h0;
    return 32'h8000_0000 | (32'(m_lvl[0]) << 29) | (32'(m_lane[0]) << 27);
  endfunction

  function automatic logic [31:0] exp_stat();
    return (32'(m_ovf) << 19) | (32'(m_cnt > 0) << 18) | 32'(m_br);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_all();
    logic [31:0] d;
    rd(12'h138, d); chk("R6", "pending", d, m_pend);
    rd(12'h13C, d); chk("R2", "mask", d, m_mask);
    rd(12'h144, d); chk("R10", "phy", d, 32'(link_up) << 11);
    rd(12'h148, d); chk("R9", "status", d, exp_stat());
    rd(12'h158, d); chk("R4", "head word1", d, exp_head());
    rd(12'h15C, d); chk("R4", "head word2", d, 32'h0);
    rd(12'h140, d); chk("R10", "unmapped 0x140", d, 32'h0);
    chk("R3", "irq", 32'(irq), 32'(|(m_pend & m_mask)));
    chk("R9", "bridge_en", 32'(bridge_en), 32'(m_br));
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      12'h138: begin
        m_pend = m_pend & ~d;
        if (m_cnt > 0) m_pend[16] = 1'b1;
      end
      12'h13C: m_mask = d;
      12'h148: begin
        m_br = d[0];
        if (d[19]) m_ovf = 1'b0;
      end
      12'h158, 12'h15C: begin
        if (m_cnt > 0) begin
          for (int i = 0; i < CAP - 1; i++) begin
            m_lane[i] = m_lane[i+1];
            m_lvl[i]  = m_lvl[i+1];
          end
          m_cnt--;
        end
      end
      default: ;
    endcase
  endtask

  task automatic do_event(input logic [1:0] lane, input logic lvl);
    @(negedge clk);
    ev_valid = 1'b1; ev_lane = lane; ev_level = lvl;
    @(negedge clk);
    ev_valid = 1'b0;
    if (m_cnt == CAP) m_ovf = 1'b1;
    else begin
      m_lane[m_cnt] = lane;
      m_lvl[m_cnt]  = lvl;
      m_cnt++;
      m_pend[16] = 1'b1;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    rst = 1'b1; ev_valid = 0; ev_lane = 0; ev_level = 0; reg_wr = 0;
    reg_addr = 0; reg_wdata = 0; link_up = 0;
    m_pend = 0; m_mask = 0; m_ovf = 0; m_br = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(12'h138, d); chk("R1", "pending after reset", d, 0);
    rd(12'h148, d); chk("R1", "status after reset", d, 0);
    rd(12'h158, d); chk("R1", "head after reset", d, 0);
    chk("R1", "irq after reset", 32'(irq), 0);
    check_all();

    // R2 full-width mask
    do_write(12'h13C, 32'hFFFF_FFFF); check_all();
    do_write(12'h13C, 32'h0001_0000); check_all();

    // R4/R7 fill and overflow
    do_event(2'd1, 1'b1); check_all();
    chk("R3", "irq after first event", 32'(irq), 1);
    do_event(2'd3, 1'b0); check_all();
    do_event(2'd2, 1'b1); check_all();
    do_event(2'd0, 1'b1);
    rd(12'h148, d); chk("R7", "overflow set on full", d, 32'h000C_0000 | 32'(m_br));
    check_all();

    // R5 clear ignored while queued
    do_write(12'h138, 32'hFFFF_FFFF);
    rd(12'h138, d); chk("R5", "intx held while queued", d, 32'h0001_0000);
    check_all();

    // R8 pop via both offsets, R4 order
    rd(12'h158, d); chk("R4", "oldest first", d, 32'hA800_0000);
    do_write(12'h15C, 32'h0); check_all();
    rd(12'h158, d); chk("R4", "second record", d, 32'h9800_0000);
    do_write(12'h158, 32'h1234); check_all();
    do_write(12'h158, 32'h0); check_all();
    do_write(12'h158, 32'h0);
    rd(12'h148, d); chk("R8", "pop on empty leaves status", d, 32'h0008_0000);
    check_all();

    // R6 clear after drain
    do_write(12'h138, 32'h0001_0000);
    rd(12'h138, d); chk("R6", "clear after drain", d, 0);
    chk("R3", "irq low after clear", 32'(irq), 0);

    // R7 sticky clear, R9 bridge
    do_write(12'h148, 32'h0000_0001);
    rd(12'h148, d); chk("R7", "overflow sticky", d, 32'h0008_0001);
    do_write(12'h148, 32'h0008_0001);
    rd(12'h148, d); chk("R7", "overflow cleared", d, 32'h0000_0001);
    chk("R9", "bridge_en high", 32'(bridge_en), 1);

    // R10 link and unmapped
    link_up = 1'b1;
    rd(12'h144, d); chk("R10", "link bit", d, 32'h0000_0800);
    rd(12'h000, d); chk("R10", "unmapped 0x000", d, 0);
    rd(12'h14C, d); chk("R10", "unmapped 0x14C", d, 0);
    check_all();

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0, 1, 2: do_event(2'($urandom), 1'($urandom));
        3: do_write(12'h138, ($urandom % 2) ? 32'h0001_0000 : $urandom);
        4: do_write(12'h13C, ($urandom % 2) ? 32'h0001_0000 : $urandom);
        5: do_write(12'h148, $urandom & 32'h0008_0001);
        6: do_write(12'h158, $urandom);
        7: do_write(12'h15C, $urandom);
        8: do_write(12'(12'h100 + 4 * ($urandom % 32)), $urandom);
        default: link_up = 1'($urandom);
      endcase
      check_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule